// File: doc/BRIEF.md
# Speculative Region Checkpoint Controller

This controller sits next to a six-stage in-order pipeline: fetch, schedule, decode, execute, memory and writeback. It inspects the word in the decode stage for three special encodings. Each one is a SETHI that writes register zero, so it does nothing on its own. Immediate 3 opens a speculative region, immediate 2 closes it and keeps its results, and immediate 1 abandons it.

The controller does not copy any registers itself. It tells the pipeline when to save register state, when to drop the saved copy and when to put it back, and it reports whether a region is open. It also ends a region by force once enough instructions have retired inside it.

The pipeline is assumed to move every valid instruction forward one stage per clock. Under that assumption, the position of a marker and of the instructions older than it can be followed from the decode cycle onward.

Top module: `txn_ckpt_ctrl`

## Requirements
- R1: A marker counts only when `dec_valid` is 1 and `dec_instr` is exactly 0x01000003 (open), 0x01000002 (close and keep) or 0x01000001 (abandon). Any other word, including the branch 0x30BFFFFF that follows an abandon marker, has no effect. A marker word presented with `dec_valid` at 0 also has no effect.
- R2: `snap_o` pulses for one cycle after an open marker is decoded. It fires in the first cycle in which none of the instructions that sat in execute or memory (`stage_valid[3]`, `stage_valid[4]`) in the decode cycle is still in flight. This is one cycle after decode when both were empty, and three cycles after decode when the execute stage was occupied.
- R3: `active_o` rises in the cycle after `snap_o` and stays at 1 until the region is closed.
- R4: A close marker decoded while a region is open raises `commit_o` in that same cycle. `active_o` is 0 from the next cycle.
- R5: An open marker decoded while a region is open raises `commit_o` in that cycle for the old region. A fresh `snap_o` then follows under the R2 timing.
- R6: An abandon marker decoded while a region is open clears `active_o` from the next cycle. `restore_o` pulses exactly three cycles after the decode cycle, when the marker reaches writeback.
- R7: A close or abandon marker decoded while no region is open raises `err_o` for that one cycle. It produces no `commit_o`, no `restore_o` and no change of `active_o`.
- R8: Each cycle with `stage_valid[5]` at 1 while `active_o` is 1 counts one retired instruction. Retirements while no region is open are not counted. The count clears whenever a region opens or closes. The cycle in which the count reaches `MAX_LEN` raises a forced `commit_o` and closes the region.
- R9: In a cycle where a forced commit fires, any marker decoded in that cycle is judged as if the region were already closed. A close marker in that cycle therefore gives a single `commit_o` together with `err_o`.
- R10: Reset (`rst_n` at 0, asynchronous) drives `active_o` and all four strobes to 0 at once, including in the middle of a region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_instr | input | 32 | Instruction word in the decode stage |
| dec_valid | input | 1 | Decode-stage word is valid |
| stage_valid | input | 6 | Per-stage valid bits; bit 0 fetch, 1 schedule, 2 decode, 3 execute, 4 memory, 5 writeback |
| snap_o | output | 1 | Save register state now |
| commit_o | output | 1 | Discard saved state; region results are kept |
| restore_o | output | 1 | Put saved state back |
| err_o | output | 1 | Close or abandon marker arrived with no open region |
| active_o | output | 1 | A speculative region is open |

## Verification
A forced commit and a decoded marker can fall in the same cycle. To provoke this, the bench opens a region and retires instructions until the count is one short of its limit. It then presents a close marker in the same cycle as the retirement that reaches the limit. The expected result is one `commit_o` pulse with `err_o` in that cycle, and `active_o` at 0 in the cycle after. That shows the marker was judged against an already-closed region and was not counted as a second commit.

// File: rtl/txn_ckpt_ctrl.sv
module txn_ckpt_ctrl #(
  parameter int MAX_LEN = 64,
  parameter int RB_LAT  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dec_instr,
  input  logic        dec_valid,
  input  logic [5:0]  stage_valid,
  output logic        snap_o,
  output logic        commit_o,
  output logic        restore_o,
  output logic        err_o,
  output logic        active_o
);
  localparam logic [31:0] W_OPEN  = 32'h0100_0003;
  localparam logic [31:0] W_CLOSE = 32'h0100_0002;
  localparam logic [31:0] W_ABORT = 32'h0100_0001;
  localparam int CW = $clog2(MAX_LEN + 1);

  logic              active_q, pend_q;
  logic [2:0]        ahead_q;
  logic [RB_LAT-1:0] rb_q;
  logic [CW-1:0]     cnt_q;

  wire retire  = stage_valid[5];
  wire force_c = active_q && retire && (cnt_q == CW'(MAX_LEN - 1));
  wire open_c  = active_q && !force_c;
  wire is_open  = dec_valid && (dec_instr == W_OPEN);
  wire is_close = dec_valid && (dec_instr == W_CLOSE);
  wire is_abort = dec_valid && (dec_instr == W_ABORT);
  wire rb_hit   = is_abort && open_c;

  assign commit_o  = force_c || (open_c && (is_close || is_open));
  assign err_o     = (is_close || is_abort) && !open_c;
  assign snap_o    = pend_q && (ahead_q == 3'b000);
  assign restore_o = rb_q[RB_LAT-1];
  assign active_o  = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      ahead_q  <= '0;
      rb_q     <= '0;
      cnt_q    <= '0;
    end else begin
      rb_q <= {rb_q[RB_LAT-2:0], rb_hit};

      if (is_open) begin
        pend_q  <= 1'b1;
        ahead_q <= {stage_valid[4], stage_valid[3], 1'b0};
      end else if (snap_o) begin
        pend_q <= 1'b0;
      end else begin
        ahead_q <= {ahead_q[1:0], 1'b0};
      end

      if (snap_o)
        active_q <= 1'b1;
      else if (commit_o || rb_hit)
        active_q <= 1'b0;

      if (snap_o || commit_o || rb_hit)
        cnt_q <= '0;
      else if (active_q && retire)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/txn_ckpt_ctrl_chk.sv
module txn_ckpt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] dec_instr,
  input logic        dec_valid,
  input logic        snap_o,
  input logic        commit_o,
  input logic        restore_o,
  input logic        err_o,
  input logic        active_o
);
  p_snap_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_o |-> !active_o);

  p_snap_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_o |=> active_o);

  p_rise_after_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(snap_o));

  p_commit_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !active_o);

  p_restore_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> !active_o);

  p_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> $past(commit_o || (dec_valid && dec_instr == 32'h0100_0001)));

  p_err_no_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !active_o) |=> !active_o || $past(snap_o));
endmodule

bind txn_ckpt_ctrl txn_ckpt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dec_instr(dec_instr), .dec_valid(dec_valid),
  .snap_o(snap_o), .commit_o(commit_o), .restore_o(restore_o),
  .err_o(err_o), .active_o(active_o)
);

// File: tb/txn_ckpt_ctrl_tb.sv
module txn_ckpt_ctrl_tb_top;
  localparam logic [31:0] NOP = 32'h0100_0000;
  localparam logic [31:0] OPN = 32'h0100_0003;
  localparam logic [31:0] CLS = 32'h0100_0002;
  localparam logic [31:0] ABT = 32'h0100_0001;
  localparam logic [31:0] BRA = 32'h30BF_FFFF;
  localparam int N = 30;

  // {instr, dec_valid, stage_valid, exp snap, commit, restore, err, active}
  localparam logic [43:0] VEC [N] = '{
    {NOP, 1'b1, 6'b000000, 5'b00000},  //  0 R1 idle
    {OPN, 1'b1, 6'b111000, 5'b00000},  //  1 R2 open with E,M,W busy
    {NOP, 1'b1, 6'b111111, 5'b00000},  //  2 R2 wait; R8 retire not counted
    {NOP, 1'b1, 6'b111111, 5'b00000},  //  3 R2 wait
    {NOP, 1'b1, 6'b100000, 5'b10000},  //  4 R2 snapshot at decode+3
    {NOP, 1'b1, 6'b100000, 5'b00001},  //  5 R3 open, count 1
    {NOP, 1'b1, 6'b100000, 5'b00001},  //  6 R8 count 2
    {NOP, 1'b1, 6'b100000, 5'b00001},  //  7 R8 count 3
    {NOP, 1'b1, 6'b100000, 5'b01001},  //  8 R8 forced commit at 4
    {CLS, 1'b1, 6'b000000, 5'b00010},  //  9 R7 close with no region
    {ABT, 1'b1, 6'b000000, 5'b00010},  // 10 R7 abandon with no region
    {OPN, 1'b1, 6'b000000, 5'b00000},  // 11 R2 open, pipe empty
    {NOP, 1'b1, 6'b000000, 5'b10000},  // 12 R2 snapshot at decode+1
    {CLS, 1'b1, 6'b000000, 5'b01001},  // 13 R4 close marker
    {OPN, 1'b1, 6'b000000, 5'b00000},  // 14 R4 region closed
    {NOP, 1'b1, 6'b000000, 5'b10000},  // 15 R2 snapshot
    {OPN, 1'b1, 6'b000000, 5'b01001},  // 16 R5 implicit commit
    {NOP, 1'b1, 6'b000000, 5'b10000},  // 17 R5 new snapshot
    {ABT, 1'b1, 6'b000000, 5'b00001},  // 18 R6 abandon accepted
    {BRA, 1'b1, 6'b000000, 5'b00000},  // 19 R1 branch word ignored, R6 closed
    {NOP, 1'b1, 6'b000000, 5'b00000},  // 20 R6 no restore yet
    {NOP, 1'b1, 6'b000000, 5'b00100},  // 21 R6 restore at decode+3
    {OPN, 1'b1, 6'b000000, 5'b00000},  // 22 R2 open
    {NOP, 1'b1, 6'b000000, 5'b10000},  // 23 R2 snapshot
    {NOP, 1'b1, 6'b100000, 5'b00001},  // 24 R8 count 1 (cleared after last region)
    {NOP, 1'b1, 6'b100000, 5'b00001},  // 25 R8 count 2
    {NOP, 1'b1, 6'b100000, 5'b00001},  // 26 R8 count 3
    {CLS, 1'b1, 6'b100000, 5'b01011},  // 27 R9 forced commit meets close marker
    {NOP, 1'b1, 6'b000000, 5'b00000},  // 28 R9 region closed
    {CLS, 1'b0, 6'b000000, 5'b00000}   // 29 R1 marker without valid
  };
  localparam int TAG [N] = '{1,2,2,2,2,3,8,8,8,7,7,2,2,4,4,2,5,5,6,1,6,6,2,2,8,8,8,9,9,1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dec_instr = '0;
  logic        dec_valid = 1'b0;
  logic [5:0]  stage_valid = '0;
  logic        snap_o, commit_o, restore_o, err_o, active_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  txn_ckpt_ctrl #(.MAX_LEN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_instr(dec_instr), .dec_valid(dec_valid),
    .stage_valid(stage_valid), .snap_o(snap_o), .commit_o(commit_o),
    .restore_o(restore_o), .err_o(err_o), .active_o(active_o)
  );

  wire [4:0] outs = {snap_o, commit_o, restore_o, err_o, active_o};

  task automatic check(input int tag, input int step, input logic [4:0] exp);
    n_chk++;
    if (outs !== exp) begin
      n_bad++;
      $display("FAIL R%0d step %0d: got %b expected %b", tag, step, outs, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic v, input logic [5:0] s);
    @(negedge clk);
    dec_instr = w; dec_valid = v; stage_valid = s;
    #5;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #5 check(10, -1, 5'b00000);  // R10 reset state
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      drive(VEC[i][43:12], VEC[i][11], VEC[i][10:5]);
      check(TAG[i], i, VEC[i][4:0]);
    end
    // R10: reset in the middle of an open region
    drive(OPN, 1'b1, 6'b000000);
    drive(NOP, 1'b1, 6'b000000);
    check(2, 100, 5'b10000);
    drive(NOP, 1'b1, 6'b000000);
    check(3, 101, 5'b00001);
    rst_n = 1'b0;
    #1 check(10, 102, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    drive(CLS, 1'b1, 6'b000000);
    check(10, 103, 5'b00010);  // R10 region gone after reset
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule